// File: doc/BRIEF.md
# Reverse Reference Clock Link

This block carries a host reference clock (4 to 28 MHz) backwards across a link, from the side that receives camera data to the camera side that sends it. It has nothing to do with the serial data clock: the two clocks share no phase and no frequency. The block holds both ends of that return path. A host-side sequencer wakes the line after power-down and plays a timed preamble on it. A camera-side detector checks that preamble, withholds the forwarded clock for a fixed settle period, and then enables a local clock output together with a ready flag. The camera's data serializer may start only once that flag is high.

The line is modelled as an enable plus a level, and the physical drivers sit outside the block. All timing is counted in ticks of `clk`, which stands for the reference clock period. While the clock is being forwarded, the line level alternates on every tick. The transmit line pair and the receive line pair are separate ports. They are normally joined by the cable model, but they can be driven independently.

Each power-down input is active low. With its power-down asserted, a side goes quiet on the next edge.

Top module: `rcl_link`

## Requirements
- R1: While `rst` is high, all outputs (`tx_line_en`, `tx_line_lvl`, `cam_clk`, `cam_ready`) are low.
- R2: While `host_pd_n` is low, the transmit line is off: `tx_line_en`=0 and `tx_line_lvl`=0 from the first edge that samples it low. An off line always has level 0.
- R3: After `host_pd_n` rises, the transmit line stays off for START_CYC+1 ticks (101 with defaults). These ticks are the edge that sees the release plus a start-up delay of START_CYC ticks. After them, `tx_line_en` goes high.
- R4: Once enabled, the line shows a preamble of LOW1_CYC ticks at 0, HIGH_CYC ticks at 1 and LOW2_CYC ticks at 0 (12/12/12 by default). After the preamble, the level alternates on every tick, starting with 1.
- R5: The detector accepts each preamble run whose length is within nominal ±TOL (default 1, so 11 to 13 ticks). Any run outside that window, or a line that comes on high, puts the detector into a fault state. In the fault state `cam_ready` stays low until the line has gone off and a fresh valid preamble arrives.
- R6: The first forwarded high tick is tick 1. Ticks 1 to 7 (SETTLE_CYC) are withheld. `cam_ready` rises on the edge that samples forwarded tick 8. From then on, `cam_clk` repeats the received level delayed by one tick.
- R7: `cam_clk` is low whenever `cam_ready` is low.
- R8: `cam_ready` and `cam_clk` drop to 0 on the first edge that samples `rx_line_en` low.
- R9: With `cam_pd_n` low, `cam_ready` and `cam_clk` are 0 from the next edge on. After `cam_pd_n` is released in the middle of a forwarded clock, the detector does not become ready without a new preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock |
| rst | input | 1 | Synchronous reset, active high |
| host_pd_n | input | 1 | Host-side power-down, active low |
| tx_line_en | output | 1 | Transmit line driven (0 = off, no current) |
| tx_line_lvl | output | 1 | Transmit line level |
| cam_pd_n | input | 1 | Camera-side power-down, active low |
| rx_line_en | input | 1 | Received line enable |
| rx_line_lvl | input | 1 | Received line level |
| cam_clk | output | 1 | Local clock output on the camera side, low until ready |
| cam_ready | output | 1 | Serializer start permission |

## Verification
The assertions check the gating rules on every cycle. These are: an off line carries level 0, the line comes on low, and the forwarded level alternates. They also check that the camera clock is low whenever ready is low, that ready drops one edge after line-off or camera power-down, and that ready rises only out of the settle state while the camera clock follows the line with a one-tick delay. Only the bench's scenarios can show the exact tick counts. These are the 101-tick quiet period, the 12/12/12 preamble, and the eighth forwarded tick on which ready rises. The scenarios also show acceptance at both edges of the tolerance window, rejection just outside it, recovery after a fault, and the fact that rejoining mid-stream never yields ready.

// File: rtl/rcl_pkg.sv
package rcl_pkg;

  typedef enum logic [2:0] {
    H_OFF,
    H_START,
    H_LOW1,
    H_HIGH,
    H_LOW2,
    H_FWD
  } host_st_e;

  typedef enum logic [2:0] {
    D_HUNT,
    D_HIGH,
    D_LOW2,
    D_SETTLE,
    D_READY,
    D_FAULT
  } det_st_e;

  // true when a measured run length lies inside nom +/- tol
  function automatic logic in_window(input int len, input int nom, input int tol);
    return (len + tol >= nom) && (len <= nom + tol);
  endfunction

endpackage

// File: rtl/rcl_host_seq.sv
module rcl_host_seq
  import rcl_pkg::*;
#(
  parameter int START_CYC = 100,
  parameter int LOW1_CYC  = 12,
  parameter int HIGH_CYC  = 12,
  parameter int LOW2_CYC  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  output logic line_en,
  output logic line_lvl
);

  localparam int MAXA = (LOW1_CYC > HIGH_CYC) ? LOW1_CYC : HIGH_CYC;
  localparam int MAXB = (MAXA > LOW2_CYC) ? MAXA : LOW2_CYC;
  localparam int MAXP = (MAXB > START_CYC) ? MAXB : START_CYC;
  localparam int CW   = $clog2(MAXP + 1);

  host_st_e        st;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   lim;
  logic            last;

  // terminal count of the phase currently being played
  always_comb begin
    case (st)
      H_START: lim = CW'(START_CYC - 1);
      H_LOW1:  lim = CW'(LOW1_CYC - 1);
      H_HIGH:  lim = CW'(HIGH_CYC - 1);
      H_LOW2:  lim = CW'(LOW2_CYC - 1);
      default: lim = '0;
    endcase
  end

  assign last = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !pd_n) begin
      st       <= H_OFF;
      cnt      <= '0;
      line_en  <= 1'b0;
      line_lvl <= 1'b0;
    end else begin
      case (st)
        H_OFF: begin
          st  <= H_START;
          cnt <= '0;
        end
        H_START: begin
          if (last) begin
            st      <= H_LOW1;
            cnt     <= '0;
            line_en <= 1'b1;
            line_lvl <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        H_LOW1: begin
          if (last) begin
            st       <= H_HIGH;
            cnt      <= '0;
            line_lvl <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        H_HIGH: begin
          if (last) begin
            st       <= H_LOW2;
            cnt      <= '0;
            line_lvl <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        H_LOW2: begin
          if (last) begin
            st       <= H_FWD;
            cnt      <= '0;
            line_lvl <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        H_FWD: begin
          line_lvl <= ~line_lvl;
        end
        default: begin
          st       <= H_OFF;
          cnt      <= '0;
          line_en  <= 1'b0;
          line_lvl <= 1'b0;
        end
      endcase
    end
  end

  AST_PD_LINE_OFF: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> (!line_en && !line_lvl)); // R2
  AST_OFF_LEVEL_LOW: assert property (@(posedge clk) disable iff (rst)
    !line_en |-> !line_lvl); // R2
  AST_QUIET_IN_START: assert property (@(posedge clk) disable iff (rst)
    (st == H_START) |-> !line_en); // R3
  AST_FIRST_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(line_en) |-> !line_lvl); // R4
  AST_FWD_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (st == H_FWD && $past(st == H_FWD)) |-> (line_lvl != $past(line_lvl))); // R4

endmodule

// File: rtl/rcl_run_meter.sv
module rcl_run_meter #(
  parameter int RUN_MAX = 14,
  parameter int RW      = $clog2(RUN_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en_i,
  input  logic          lvl_i,
  output logic [RW-1:0] run_o,
  output logic          prev_en_o,
  output logic          prev_lvl_o
);

  // run_o holds how many consecutive samples the line has shown its
  // current level; it saturates at RUN_MAX and is 0 while the line is off
  always_ff @(posedge clk) begin
    if (rst || clr || !en_i) begin
      run_o      <= '0;
      prev_en_o  <= 1'b0;
      prev_lvl_o <= 1'b0;
    end else begin
      if (!prev_en_o || (lvl_i != prev_lvl_o)) begin
        run_o <= RW'(1);
      end else if (run_o != RW'(RUN_MAX)) begin
        run_o <= run_o + 1'b1;
      end
      prev_en_o  <= 1'b1;
      prev_lvl_o <= lvl_i;
    end
  end

endmodule

// File: rtl/rcl_cam_det.sv
module rcl_cam_det
  import rcl_pkg::*;
#(
  parameter int LOW1_CYC   = 12,
  parameter int HIGH_CYC   = 12,
  parameter int LOW2_CYC   = 12,
  parameter int TOL        = 1,
  parameter int SETTLE_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  input  logic rx_en,
  input  logic rx_lvl,
  output logic cam_clk,
  output logic cam_ready
);

  localparam int MAXA    = (LOW1_CYC > HIGH_CYC) ? LOW1_CYC : HIGH_CYC;
  localparam int MAXB    = (MAXA > LOW2_CYC) ? MAXA : LOW2_CYC;
  localparam int RUN_MAX = MAXB + TOL + 1;
  localparam int RW      = $clog2(RUN_MAX + 1);
  localparam int SW      = $clog2(SETTLE_CYC + 1);

  det_st_e        ds;
  logic [SW-1:0]  sc;
  logic [RW-1:0]  run;
  logic           prev_en;
  logic           prev_lvl;
  logic           rise;
  logic           fall;
  logic           first_on;
  logic           stuck_high;

  rcl_run_meter #(
    .RUN_MAX (RUN_MAX),
    .RW      (RW)
  ) u_meter (
    .clk        (clk),
    .rst        (rst),
    .clr        (!pd_n),
    .en_i       (rx_en),
    .lvl_i      (rx_lvl),
    .run_o      (run),
    .prev_en_o  (prev_en),
    .prev_lvl_o (prev_lvl)
  );

  assign rise       = rx_en && prev_en && rx_lvl && !prev_lvl;
  assign fall       = rx_en && prev_en && !rx_lvl && prev_lvl;
  assign first_on   = rx_en && !prev_en;
  assign stuck_high = rx_en && rx_lvl && (run == RW'(RUN_MAX));

  always_ff @(posedge clk) begin
    if (rst || !pd_n || !rx_en) begin
      ds        <= D_HUNT;
      sc        <= '0;
      cam_ready <= 1'b0;
      cam_clk   <= 1'b0;
    end else begin
      case (ds)
        D_HUNT: begin
          if (first_on && rx_lvl) begin
            ds <= D_FAULT;
          end else if (rise) begin
            ds <= in_window(32'(run), LOW1_CYC, TOL) ? D_HIGH : D_FAULT;
          end
        end
        D_HIGH: begin
          if (fall) begin
            ds <= in_window(32'(run), HIGH_CYC, TOL) ? D_LOW2 : D_FAULT;
          end else if (stuck_high) begin
            ds <= D_FAULT;
          end
        end
        D_LOW2: begin
          if (rise) begin
            if (in_window(32'(run), LOW2_CYC, TOL)) begin
              ds <= D_SETTLE;
              sc <= SW'(1);
            end else begin
              ds <= D_FAULT;
            end
          end
        end
        D_SETTLE: begin
          if (sc == SW'(SETTLE_CYC)) begin
            ds        <= D_READY;
            cam_ready <= 1'b1;
            cam_clk   <= rx_lvl;
          end else begin
            sc <= sc + 1'b1;
          end
        end
        D_READY: begin
          cam_clk <= rx_lvl;
        end
        D_FAULT: begin
          ds <= D_FAULT;
        end
        default: begin
          ds <= D_HUNT;
        end
      endcase
    end
  end

  AST_CLK_GATED: assert property (@(posedge clk) disable iff (rst)
    !cam_ready |-> !cam_clk); // R7
  AST_LINE_OFF_DROPS: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!cam_ready && !cam_clk)); // R8
  AST_PD_DROPS: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> (!cam_ready && !cam_clk)); // R9
  AST_READY_FROM_SETTLE: assert property (@(posedge clk) disable iff (rst)
    $rose(cam_ready) |-> $past(ds == D_SETTLE)); // R6
  AST_CLK_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (rst)
    (cam_ready && $past(cam_ready)) |-> (cam_clk == $past(rx_lvl))); // R6

endmodule

// File: rtl/rcl_link.sv
module rcl_link #(
  parameter int START_CYC  = 100,
  parameter int LOW1_CYC   = 12,
  parameter int HIGH_CYC   = 12,
  parameter int LOW2_CYC   = 12,
  parameter int TOL        = 1,
  parameter int SETTLE_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic host_pd_n,
  output logic tx_line_en,
  output logic tx_line_lvl,
  input  logic cam_pd_n,
  input  logic rx_line_en,
  input  logic rx_line_lvl,
  output logic cam_clk,
  output logic cam_ready
);

  rcl_host_seq #(
    .START_CYC (START_CYC),
    .LOW1_CYC  (LOW1_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .LOW2_CYC  (LOW2_CYC)
  ) u_host (
    .clk      (clk),
    .rst      (rst),
    .pd_n     (host_pd_n),
    .line_en  (tx_line_en),
    .line_lvl (tx_line_lvl)
  );

  rcl_cam_det #(
    .LOW1_CYC   (LOW1_CYC),
    .HIGH_CYC   (HIGH_CYC),
    .LOW2_CYC   (LOW2_CYC),
    .TOL        (TOL),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_det (
    .clk       (clk),
    .rst       (rst),
    .pd_n      (cam_pd_n),
    .rx_en     (rx_line_en),
    .rx_lvl    (rx_line_lvl),
    .cam_clk   (cam_clk),
    .cam_ready (cam_ready)
  );

endmodule

// File: tb/rcl_link_tb.sv
`timescale 1ns/1ps
module rcl_link_tb;

  localparam int ST   = 100;
  localparam int LEN  = 12;
  localparam int SETL = 7;
  localparam int BASE = ST + 1;            // first tick with line on
  localparam int F1   = BASE + 3 * LEN;    // first forwarded tick
  localparam int RDY  = F1 + SETL + 1;     // first tick showing ready

  typedef struct {
    bit    ml; bit en; bit lvl; string rql;
    bit    mr; bit rdy; bit mc; bit cclk; string rqc;
  } exp_t;

  logic clk = 1'b0;
  logic rst;
  logic host_pd_n, cam_pd_n;
  logic tx_line_en, tx_line_lvl;
  logic ovr, ovr_en, ovr_lvl;
  logic rx_line_en, rx_line_lvl;
  logic cam_clk, cam_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  assign rx_line_en  = ovr ? ovr_en  : tx_line_en;
  assign rx_line_lvl = ovr ? ovr_lvl : tx_line_lvl;

  rcl_link u_dut (
    .clk         (clk),
    .rst         (rst),
    .host_pd_n   (host_pd_n),
    .tx_line_en  (tx_line_en),
    .tx_line_lvl (tx_line_lvl),
    .cam_pd_n    (cam_pd_n),
    .rx_line_en  (rx_line_en),
    .rx_line_lvl (rx_line_lvl),
    .cam_clk     (cam_clk),
    .cam_ready   (cam_ready)
  );

  // monitor: pops one expected item per cycle and compares
  always @(negedge clk) begin
    exp_t e;
    if (q.size() != 0) begin
      e = q.pop_front();
      if (e.ml) begin
        checks++;
        if ({tx_line_en, tx_line_lvl} !== {e.en, e.lvl}) begin
          errors++;
          $display("FAIL %s line en/lvl actual %b%b expected %b%b", e.rql,
                   tx_line_en, tx_line_lvl, e.en, e.lvl);
        end
      end
      if (e.mr) begin
        checks++;
        if (cam_ready !== e.rdy) begin
          errors++;
          $display("FAIL %s cam_ready actual %b expected %b", e.rqc, cam_ready, e.rdy);
        end
      end
      if (e.mc) begin
        checks++;
        if (cam_clk !== e.cclk) begin
          errors++;
          $display("FAIL %s cam_clk actual %b expected %b", e.rqc, cam_clk, e.cclk);
        end
      end
    end
  end

  task automatic tick(input exp_t e);
    q.push_back(e);
    @(posedge clk);
    #1;
  endtask

  function automatic exp_t mk(bit ml, bit en, bit lvl, string rql,
                              bit mr, bit rdy, bit mc, bit cclk, string rqc);
    exp_t e;
    e.ml = ml; e.en = en; e.lvl = lvl; e.rql = rql;
    e.mr = mr; e.rdy = rdy; e.mc = mc; e.cclk = cclk; e.rqc = rqc;
    return e;
  endfunction

  // host start-up through the own cable; optional camera power-down window
  task automatic startup(input int len, input int cam_off_at);
    host_pd_n = 1'b1;
    for (int k = 0; k < len; k++) begin
      bit on, lv, r, c, cam_gone;
      string rl, rc;
      if (k == cam_off_at) cam_pd_n = 1'b0;
      if (cam_off_at >= 0 && k == cam_off_at + 10) cam_pd_n = 1'b1;
      on = (k >= BASE);
      if (k < BASE)                lv = 1'b0;
      else if (k < BASE + LEN)     lv = 1'b0;
      else if (k < BASE + 2 * LEN) lv = 1'b1;
      else if (k < F1)             lv = 1'b0;
      else                         lv = ((k - F1) % 2 == 0);
      cam_gone = (cam_off_at >= 0) && (k > cam_off_at);
      r  = (k >= RDY) && !cam_gone;
      c  = r && ((k - F1 - 1) % 2 == 0);
      rl = (k < BASE) ? "R3" : "R4";
      rc = cam_gone ? "R9" : "R6";
      tick(mk(1'b1, on, lv, rl, 1'b1, r, 1'b1, c, rc));
    end
  endtask

  // host power-down while the forwarded clock runs (R2, R8)
  task automatic host_off(input int n, input bit prior_rdy);
    host_pd_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i == 0)      tick(mk(1'b0, 1'b0, 1'b0, "R2", 1'b1, prior_rdy, 1'b0, 1'b0, "R8"));
      else if (i == 1) tick(mk(1'b1, 1'b0, 1'b0, "R2", 1'b1, prior_rdy, 1'b0, 1'b0, "R8"));
      else             tick(mk(1'b1, 1'b0, 1'b0, "R2", 1'b1, 1'b0, 1'b1, 1'b0, "R8"));
    end
  endtask

  // bench-driven receive line: preamble runs, forwarded ticks, then off
  task automatic ovr_seq(input int lo1, input int hi, input int lo2, input int nf, input bit ok);
    string rc;
    rc = ok ? "R6" : "R5";
    ovr = 1'b1;
    for (int i = 0; i < lo1 + hi + lo2; i++) begin
      ovr_en  = 1'b1;
      ovr_lvl = (i >= lo1) && (i < lo1 + hi);
      tick(mk(1'b1, 1'b0, 1'b0, "R2", 1'b1, 1'b0, 1'b1, 1'b0, "R5"));
    end
    for (int k = 1; k <= nf; k++) begin
      bit r, c;
      ovr_lvl = (k % 2 == 1);
      r = ok && (k >= SETL + 2);
      c = r && ((k - 1) % 2 == 1);
      tick(mk(1'b1, 1'b0, 1'b0, "R2", 1'b1, r, 1'b1, c, rc));
    end
    ovr_en  = 1'b0;
    ovr_lvl = 1'b0;
    tick(mk(1'b1, 1'b0, 1'b0, "R2", 1'b1, ok, 1'b0, 1'b0, "R8"));
    tick(mk(1'b1, 1'b0, 1'b0, "R2", 1'b1, 1'b0, 1'b1, 1'b0, "R8"));
  endtask

  initial begin
    rst = 1'b1; host_pd_n = 1'b0; cam_pd_n = 1'b1;
    ovr = 1'b0; ovr_en = 1'b0; ovr_lvl = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    tick(mk(1'b1, 1'b0, 1'b0, "R1", 1'b1, 1'b0, 1'b1, 1'b0, "R1"));
    tick(mk(1'b1, 1'b0, 1'b0, "R1", 1'b1, 1'b0, 1'b1, 1'b0, "R1"));
    rst = 1'b0;
    startup(RDY + 30, -1);      // R3 R4 R6 R7
    host_off(12, 1'b1);         // R2 R8
    startup(RDY + 55, RDY + 15); // R9: camera power-down, mid-stream rejoin
    host_off(12, 1'b0);
    ovr_seq(12, 12, 12, 20, 1'b1); // R6 nominal
    ovr_seq(11, 13, 11, 20, 1'b1); // R5 window edges accepted
    ovr_seq(13, 11, 13, 20, 1'b1); // R5 window edges accepted
    ovr_seq(12, 14, 12, 20, 1'b0); // R5 high run too long
    ovr_seq(10, 12, 12, 20, 1'b0); // R5 first low too short
    ovr_seq(12, 12, 14, 20, 1'b0); // R5 last low too long
    ovr_seq(12, 12, 12, 20, 1'b1); // R5 recovery after fault
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule